// File: doc/BRIEF.md
# Packetized DRAM Read Sequencer

This block is the controller-side engine that carries out a single read on a packetized DRAM channel. A request names a device, a bank and a row. After accepting it, the engine sends a 24-bit row packet as eight 3-bit groups on a narrow command bus, one group per tick. It then waits out the channel's fixed access latency and captures eight 18-bit transfers from the data bus. It checks even parity on every byte and hands back one 144-bit word with a parity-error flag.

The engine runs from a clock at the transfer rate, which is twice the bus clock. One bus clock of 20 cycles of latency is therefore 40 ticks, and the four-clock data burst is 8 ticks. Only one read can be in flight at a time, because the channel allows a single active device. New requests are held off with a valid/ready handshake until the response has been taken.

Top module: `pkt_rd_seq`

## Requirements
- R1: While reset is held and on the tick after it, `req_ready` is 1, `rsp_valid` is 0, `row_vld` is 0 and `row_o` is 0.
- R2: A request is accepted only on an edge where `req_valid` and `req_ready` are both 1. From that edge until the response has been taken, `req_ready` is 0, and request inputs presented during that time have no effect on the packet or on the response.
- R3: The row packet is the 24-bit value with the device in bits [5:0], the bank in [9:6], the row in [18:10] and zeros in [23:19]. It is sent on `row_o` as group k = bits [3k+2:3k], in ticks 0 to 7, where tick 0 is the tick right after the accepting edge. `row_vld` is 1 in exactly those ticks, and `row_o` is 0 in every other tick.
- R4: Data transfer i (0 to 7) is taken from `dq_i` as it stands in tick 40+i, which is 40 ticks (20 bus clocks) after the row packet starts.
- R5: Transfer i occupies bits [18i+17:18i] of `rsp_word`, so transfer 0 sits in the least-significant 18 bits.
- R6: Each transfer carries data in [15:0] and parity in [17:16]. Bit 16 is even parity over [7:0] and bit 17 is even parity over [15:8]. `rsp_perr` is 1 if and only if at least one of the eight transfers fails either check.
- R7: `rsp_valid` rises in tick 48. It stays 1, with `rsp_word` and `rsp_perr` unchanged, until an edge where `rsp_ready` is 1.
- R8: On the tick after the response handshake, `rsp_valid` is 0 and `req_ready` is 1.
- R9: A synchronous reset taken in the middle of a read abandons that read. The engine is idle on the next tick, and a later read completes normally.
- R10: Values on `dq_i` outside ticks 40 to 47 of a read have no effect on the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transfer-rate clock (twice the bus clock) |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_dev | input | 6 | Target device address |
| req_bank | input | 4 | Target bank |
| req_row | input | 9 | Target row |
| row_o | output | 3 | Row packet group for the current tick |
| row_vld | output | 1 | Row packet group is being driven |
| dq_i | input | 18 | Data transfer: data [15:0], byte parity [17:16] |
| rsp_valid | output | 1 | Assembled word available |
| rsp_ready | input | 1 | Consumer takes the word |
| rsp_word | output | 144 | Eight transfers, transfer 0 in the low bits |
| rsp_perr | output | 1 | Some transfer failed its parity check |

## Verification
The assertions assume the response consumer may hold off `rsp_ready` for any number of ticks. They also assume `req_valid` can stay high while a read is in flight, and that reset can arrive at any tick. The stimulus covers all three conditions: it keeps `req_valid` high with unrelated field values throughout every read, delays `rsp_ready` by a different number of ticks per vector, and pulls reset in the middle of a read. Between reads, `req_valid` is dropped before the response handshake, so no second request is taken before the check of the idle state.

// File: rtl/pkt_rd_pkg.sv
// Shared types and defaults for the packetized read sequencer.
// Assumes: none beyond IEEE 1800-2017.
package pkt_rd_pkg;

    localparam int DEV_W_D  = 6;
    localparam int BANK_W_D = 4;
    localparam int ROW_W_D  = 9;
    localparam int LANES_D  = 3;
    localparam int XFERS_D  = 8;
    localparam int BYTES_D  = 2;
    localparam int LAT_D    = 40;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_RESP = 2'd2
    } seq_state_t;

endpackage

// File: rtl/pkt_rd_ctrl.sv
// Sequencing control: owns the idle/busy/response state and the tick counter.
// Raises the command phase for the first XFERS ticks and the capture window
// for ticks LAT .. LAT+XFERS-1, then offers the response.
// Assumes: LAT >= XFERS, so the packet ends before data starts.
module pkt_rd_ctrl
    import pkt_rd_pkg::*;
#(
    parameter int LAT   = LAT_D,
    parameter int XFERS = XFERS_D,
    localparam int LAST  = LAT + XFERS - 1,
    localparam int CNT_W = $clog2(LAST + 1),
    localparam int XI_W  = $clog2(XFERS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic            accept_o,
    output logic            cmd_phase_o,
    output logic            cap_en_o,
    output logic [XI_W-1:0] slot_o
);

    seq_state_t       state;
    logic [CNT_W-1:0] cnt;

    assign req_ready = (state == ST_IDLE);
    assign rsp_valid = (state == ST_RESP);
    assign accept_o  = req_valid && req_ready;

    // Next state and tick count per transfer-rate clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (req_valid) begin
                    state <= ST_BUSY;
                    cnt   <= '0;
                end
                ST_BUSY: begin
                    if (cnt == CNT_W'(LAST)) state <= ST_RESP;
                    cnt <= cnt + 1'b1;
                end
                ST_RESP: if (rsp_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Phase decode: packet window first, capture window after the latency.
    always_comb begin
        cmd_phase_o = (state == ST_BUSY) && (cnt < CNT_W'(XFERS));
        cap_en_o    = (state == ST_BUSY) && (cnt >= CNT_W'(LAT));
        slot_o      = cmd_phase_o ? cnt[XI_W-1:0] : XI_W'(cnt - CNT_W'(LAT));
    end

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> !req_ready); // R2
    AST_RSP_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) |-> $past(cap_en_o)); // R7

endmodule

// File: rtl/pkt_rd_ser.sv
// Row packet serializer: latches device, bank and row on acceptance and
// sends the packet one LANES-wide group per tick, group 0 first.
// Assumes: LANES*XFERS >= DEV_W+BANK_W+ROW_W; unused high bits go out as 0.
module pkt_rd_ser #(
    parameter int DEV_W  = pkt_rd_pkg::DEV_W_D,
    parameter int BANK_W = pkt_rd_pkg::BANK_W_D,
    parameter int ROW_W  = pkt_rd_pkg::ROW_W_D,
    parameter int LANES  = pkt_rd_pkg::LANES_D,
    parameter int XFERS  = pkt_rd_pkg::XFERS_D,
    localparam int PKT_W = LANES * XFERS,
    localparam int XI_W  = $clog2(XFERS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [DEV_W-1:0]  dev,
    input  logic [BANK_W-1:0] bank,
    input  logic [ROW_W-1:0]  row,
    input  logic              cmd_phase,
    input  logic [XI_W-1:0]   slot,
    output logic [LANES-1:0]  row_o,
    output logic              row_vld
);

    logic [PKT_W-1:0]            pkt;
    logic [XFERS-1:0][LANES-1:0] groups;

    // Capture the packet fields on the accepting edge only.
    always_ff @(posedge clk) begin
        if (!rst_n) pkt <= '0;
        else if (accept) pkt <= PKT_W'({row, bank, dev});
    end

    genvar g;
    generate
        for (g = 0; g < XFERS; g++) begin : g_grp
            assign groups[g] = pkt[g*LANES +: LANES];
        end
    endgenerate

    // Drive the current group during the packet window, idle low otherwise.
    always_comb begin
        row_vld = cmd_phase;
        row_o   = cmd_phase ? groups[slot] : '0;
    end

    AST_PKT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(row_vld) |-> $past(accept)); // R3

endmodule

// File: rtl/pkt_rd_asm.sv
// Data assembler: stores each captured transfer in its own slot of the
// response word and folds per-byte even-parity failures into a sticky flag.
// Assumes: slot is valid whenever cap_en is high; accept clears the flag.
module pkt_rd_asm #(
    parameter int XFERS = pkt_rd_pkg::XFERS_D,
    parameter int BYTES = pkt_rd_pkg::BYTES_D,
    localparam int DW     = 8 * BYTES,
    localparam int BUS_W  = DW + BYTES,
    localparam int WORD_W = BUS_W * XFERS,
    localparam int XI_W   = $clog2(XFERS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              cap_en,
    input  logic [XI_W-1:0]   slot,
    input  logic [BUS_W-1:0]  dq,
    output logic [WORD_W-1:0] word,
    output logic              perr
);

    logic [BYTES-1:0] byte_bad;

    genvar b, s;
    generate
        for (b = 0; b < BYTES; b++) begin : g_par
            // Even parity: the byte plus its parity bit must hold an even count of ones.
            assign byte_bad[b] = (^dq[b*8 +: 8]) ^ dq[DW + b];
        end
        for (s = 0; s < XFERS; s++) begin : g_slot
            // Load this slot only in its own capture tick.
            always_ff @(posedge clk) begin
                if (!rst_n) word[s*BUS_W +: BUS_W] <= '0;
                else if (cap_en && slot == XI_W'(s)) word[s*BUS_W +: BUS_W] <= dq;
            end
        end
    endgenerate

    // Sticky parity error, cleared when a new read starts.
    always_ff @(posedge clk) begin
        if (!rst_n) perr <= 1'b0;
        else if (accept) perr <= 1'b0;
        else if (cap_en && |byte_bad) perr <= 1'b1;
    end

    AST_PERR_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(perr) |-> $past(cap_en)); // R6

endmodule

// File: rtl/pkt_rd_seq.sv
// Packetized DRAM read sequencer top: one read at a time, row packet out,
// fixed-latency capture of the data burst, word and parity flag back.
// Assumes: clk runs at the transfer rate (two ticks per bus clock).
module pkt_rd_seq
    import pkt_rd_pkg::*;
#(
    parameter int DEV_W  = DEV_W_D,
    parameter int BANK_W = BANK_W_D,
    parameter int ROW_W  = ROW_W_D,
    parameter int LANES  = LANES_D,
    parameter int XFERS  = XFERS_D,
    parameter int BYTES  = BYTES_D,
    parameter int LAT    = LAT_D,
    localparam int BUS_W  = 9 * BYTES,
    localparam int WORD_W = BUS_W * XFERS,
    localparam int XI_W   = $clog2(XFERS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DEV_W-1:0]  req_dev,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    output logic [LANES-1:0]  row_o,
    output logic              row_vld,
    input  logic [BUS_W-1:0]  dq_i,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [WORD_W-1:0] rsp_word,
    output logic              rsp_perr
);

    logic            accept;
    logic            cmd_phase;
    logic            cap_en;
    logic [XI_W-1:0] slot;

    pkt_rd_ctrl #(.LAT(LAT), .XFERS(XFERS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .accept_o(accept), .cmd_phase_o(cmd_phase),
        .cap_en_o(cap_en), .slot_o(slot)
    );

    pkt_rd_ser #(.DEV_W(DEV_W), .BANK_W(BANK_W), .ROW_W(ROW_W),
                 .LANES(LANES), .XFERS(XFERS)) u_ser (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .dev(req_dev), .bank(req_bank), .row(req_row),
        .cmd_phase(cmd_phase), .slot(slot),
        .row_o(row_o), .row_vld(row_vld)
    );

    pkt_rd_asm #(.XFERS(XFERS), .BYTES(BYTES)) u_asm (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .cap_en(cap_en), .slot(slot), .dq(dq_i),
        .word(rsp_word), .perr(rsp_perr)
    );

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_word) && $stable(rsp_perr)); // R7
    AST_RETURN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> req_ready && !rsp_valid); // R8
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && (row_vld || rsp_valid))); // R2

endmodule

// File: tb/tb_pkt_rd_seq.sv
module tb_pkt_rd_seq;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid, rsp_ready;
    logic [5:0]   req_dev;
    logic [3:0]   req_bank;
    logic [8:0]   req_row;
    logic [17:0]  dq_i;
    logic         req_ready, row_vld, rsp_valid, rsp_perr;
    logic [2:0]   row_o;
    logic [143:0] rsp_word;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    pkt_rd_seq dut (.*);

    typedef struct packed {
        logic [5:0]  dev;
        logic [3:0]  bank;
        logic [8:0]  row;
        logic [15:0] base;
        logic [3:0]  badx;   // transfer with corrupted parity, 8 = none
        logic        badhi;  // corrupt the high-byte parity bit
        logic [3:0]  dly;    // ticks before rsp_ready
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{6'd0,  4'd0,  9'd0,   16'h0000, 4'd8, 1'b0, 4'd0},
        '{6'd63, 4'd15, 9'd511, 16'hFFFF, 4'd8, 1'b0, 4'd2},
        '{6'd21, 4'd10, 9'd341, 16'hA5C3, 4'd8, 1'b0, 4'd5},
        '{6'd1,  4'd8,  9'd256, 16'h1234, 4'd0, 1'b0, 4'd1},
        '{6'd42, 4'd5,  9'd170, 16'hBEEF, 4'd7, 1'b1, 4'd0},
        '{6'd33, 4'd3,  9'd77,  16'h0F0F, 4'd3, 1'b1, 4'd3}
    };

    task automatic chk(input bit ok, input string req, input logic [143:0] act, input logic [143:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [17:0] xfer(input int i, input logic [15:0] base,
                                         input logic [3:0] badx, input logic badhi);
        logic [15:0] d;
        logic p0, p1;
        d  = base ^ (16'h2469 * 16'(i + 1));
        p0 = ^d[7:0];
        p1 = ^d[15:8];
        if (badx == 4'(i)) begin
            if (badhi) p1 = ~p1; else p0 = ~p0;
        end
        return {p1, p0, d};
    endfunction

    task automatic run(input vec_t v);
        logic [23:0]  pkt;
        logic [143:0] exp_w;
        bit           row_ok = 1;
        bit           idle_ok = 1;
        pkt = {5'b0, v.row, v.bank, v.dev};
        for (int i = 0; i < 8; i++) exp_w[18*i +: 18] = xfer(i, v.base, v.badx, v.badhi);
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready before request", 144'(req_ready), 144'd1);
        req_valid = 1'b1; req_dev = v.dev; req_bank = v.bank; req_row = v.row;
        @(posedge clk);
        for (int t = 0; t < 48; t++) begin
            @(negedge clk);
            req_dev = ~v.dev; req_bank = ~v.bank; req_row = ~v.row;   // ignored while busy (R2)
            dq_i = (t >= 40) ? xfer(t - 40, v.base, v.badx, v.badhi) : (18'h2AAAA ^ 18'(t)); // R10 junk
            if (t < 8) begin
                if (!(row_vld && row_o == pkt[3*t +: 3])) row_ok = 0;
            end else if (row_vld || row_o != 3'b0) row_ok = 0;
            if (req_ready || rsp_valid) idle_ok = 0;
        end
        chk(row_ok, "R3 row packet groups", 144'(row_o), 144'(pkt));
        chk(idle_ok, "R2 busy with no ready", 144'(req_ready), 144'd0);
        @(negedge clk);
        req_valid = 1'b0; dq_i = 18'h15555;   // R10 junk after window
        chk(rsp_valid == 1'b1, "R7 valid in tick 48", 144'(rsp_valid), 144'd1);
        chk(rsp_word == exp_w, "R4 R5 assembled word", rsp_word, exp_w);
        chk(rsp_perr == (v.badx != 4'd8), "R6 parity flag", 144'(rsp_perr), 144'(v.badx != 4'd8));
        for (int d = 0; d < int'(v.dly); d++) @(negedge clk);
        chk(rsp_valid && rsp_word == exp_w, "R7 held until ready", rsp_word, exp_w);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(req_ready && !rsp_valid, "R8 idle after handshake", 144'({req_ready, rsp_valid}), 144'b10);
    endtask

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0;
        req_dev = '0; req_bank = '0; req_row = '0; dq_i = '0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(req_ready && !rsp_valid && !row_vld && row_o == 3'b0, "R1 reset state",
            144'({req_ready, rsp_valid, row_vld, row_o}), 144'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !row_vld, "R1 first tick after reset",
            144'({req_ready, rsp_valid, row_vld}), 144'b100);

        foreach (VECS[k]) run(VECS[k]);

        // R9: reset in the middle of a read
        @(negedge clk);
        req_valid = 1'b1; req_dev = 6'd9; req_bank = 4'd2; req_row = 9'd3;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (20) @(negedge clk);
        chk(!req_ready, "R9 busy before abort", 144'(req_ready), 144'd0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready && !rsp_valid && !row_vld, "R9 idle after abort",
            144'({req_ready, rsp_valid, row_vld}), 144'b100);
        rst_n = 1'b1;
        repeat (50) @(negedge clk);
        chk(!rsp_valid && !row_vld, "R9 no leftover response", 144'({rsp_valid, row_vld}), 144'd0);
        run(VECS[2]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule